// File: doc/BRIEF.md
# Virtual Channel Stream Gasket

The gasket sits between a camera serial receiver and an image-processing front end. Each input beat carries one 32-bit word of decoded payload, a 2-bit virtual channel tag and a 6-bit data type. The gasket sends that word, as two 16-bit beats, to the output port whose index equals the virtual channel. On the way it applies the repacking that the control register selects for RGB444 and 8-bit YUV422 payloads.

Each output port has a valid/ready handshake, an 8-bit data identifier and a pixel-clock enable. The identifier carries only the data type: its channel bits are cleared. The input is held off until both halves of the current word have left, so no data is lost under backpressure. A software reset bit in the control register may be set while traffic is running. It discards any word in flight and keeps the block idle for as long as it stays set.

Top module: `vc_stream_gasket`

## Requirements
- R1: A word accepted on the input leaves as two 16-bit beats on one port. For data types other than RGB444 and 8-bit YUV422, the first beat is in_data[15:0] and the second is in_data[31:16].
- R2: A word tagged with virtual channel n raises out_valid only on port n. Every other port shows out_valid low and a zero data slice. Port n's data occupies out_data[16n+15:16n].
- R3: While port n is valid, its identifier out_di[8n+7:8n] equals {2'b00, data type}. The channel tag is always cleared.
- R4: Control register fields are: bit 0 soft reset, bit 1 free-running clock (1 = non-gated), bit 2 YUV order (1 = U-Y-V-Y), bit 3 RGB444 layout. Bits 31:4 ignore writes and read as zero. After reset the register reads 0.
- R5: For data type 0x20 (RGB444), each 16-bit half holds a pixel with r in [11:8], g in [7:4] and b in [3:0]. With bit 3 = 0 the beat is {4'h0, r, g, b}. With bit 3 = 1 it is {r, 1'b0, g, 2'b00, b, 1'b0}.
- R6: For data type 0x1E (8-bit YUV422), input bytes b0..b3 sit at in_data[7:0] up to [31:24]. With bit 2 = 1 the beats are {b1,b0} then {b3,b2}. With bit 2 = 0 the bytes inside each beat are swapped: {b0,b1} then {b2,b3}.
- R7: For every data type other than 0x20 and 0x1E, bits 2 and 3 have no effect on the output beats. The mode bits are sampled when a word is accepted.
- R8: With bit 1 = 0, out_pclk_en equals out_valid on every port. With bit 1 = 1, all pixel-clock enables are high.
- R9: A beat that is valid but not ready stays valid and unchanged. in_ready stays low until the second beat of the current word is taken, and is only then allowed to accept the next word in that same cycle.
- R10: From the cycle after a write that sets bit 0, all out_valid and in_ready are low, and they stay low while the bit is set. A word that was only half sent is discarded and does not reappear after the bit is cleared.
- R11: While reset is asserted and just after it is released, all out_valid are low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Control register write strobe |
| cfg_wr_data | input | 32 | Control register write value |
| cfg_rd_data | output | 32 | Control register read value |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted when high with in_valid |
| in_data | input | 32 | Input payload word |
| in_vc | input | 2 | Virtual channel of the input word |
| in_dt | input | 6 | Data type of the input word |
| out_valid | output | 4 | Per-port beat valid |
| out_ready | input | 4 | Per-port beat ready |
| out_data | output | 64 | Per-port 16-bit beat, port n in bits 16n+15:16n |
| out_di | output | 32 | Per-port data identifier, port n in bits 8n+7:8n |
| out_pclk_en | output | 4 | Per-port pixel-clock enable |

## Verification
The assertions assume that the downstream side never depends on out_ready to drive a valid beat. They also assume that the control register changes only through cfg_wr_en, so that a soft-reset write is the only event that may drop a stalled beat. The stimulus sweeps all four channels and a mix of four data types under all eight mode combinations, with ready held high. It then runs separate stall and soft-reset scenarios, and during those scenarios it writes the register only at points the assertions tolerate.

// File: rtl/vcg_pkg.sv
package vcg_pkg;
  localparam logic [5:0] DT_RGB444  = 6'h20;
  localparam logic [5:0] DT_YUV422B = 6'h1E;

  typedef struct packed {
    logic rgb_alt;    // bit 3
    logic yuv_uyvy;   // bit 2
    logic free_clk;   // bit 1
    logic soft_rst;   // bit 0
  } vcg_cfg_t;
endpackage

// File: rtl/vcg_ctrl_reg.sv
module vcg_ctrl_reg
  import vcg_pkg::*;
#(
  parameter int unsigned REG_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output vcg_cfg_t         cfg,
  output logic [REG_W-1:0] rd_data
);
  localparam int unsigned CFG_W = $bits(vcg_cfg_t);

  vcg_cfg_t cfg_q, cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (wr_en) cfg_d = vcg_cfg_t'(wr_data[CFG_W-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end

  assign cfg     = cfg_q;
  assign rd_data = {{(REG_W-CFG_W){1'b0}}, cfg_q};
endmodule

// File: rtl/vcg_packer.sv
module vcg_packer
  import vcg_pkg::*;
#(
  parameter int unsigned OUT_W = 16,
  parameter int unsigned DT_W  = 6
) (
  input  logic [2*OUT_W-1:0] word_in,
  input  logic [DT_W-1:0]    dt,
  input  vcg_cfg_t           cfg,
  output logic [2*OUT_W-1:0] word_out
);
  localparam int unsigned NHALF = 2;

  for (genvar h = 0; h < NHALF; h++) begin : g_half
    logic [OUT_W-1:0] src, rgb_v, yuv_v, res;
    logic [3:0]       r, g, b;

    assign src = word_in[h*OUT_W +: OUT_W];
    assign r   = src[11:8];
    assign g   = src[7:4];
    assign b   = src[3:0];

    always_comb begin
      if (cfg.rgb_alt) rgb_v = OUT_W'({r, 1'b0, g, 2'b00, b, 1'b0});
      else             rgb_v = OUT_W'({4'h0, r, g, b});
      if (cfg.yuv_uyvy) yuv_v = src;
      else              yuv_v = {src[7:0], src[15:8]};
      if (dt == DT_RGB444)       res = rgb_v;
      else if (dt == DT_YUV422B) res = yuv_v;
      else                       res = src;
    end

    assign word_out[h*OUT_W +: OUT_W] = res;
  end
endmodule

// File: rtl/vcg_beat_buf.sv
module vcg_beat_buf #(
  parameter int unsigned OUT_W = 16,
  parameter int unsigned DT_W  = 6,
  parameter int unsigned VC_W  = 2,
  parameter int unsigned NPORT = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [2*OUT_W-1:0] in_word,
  input  logic [VC_W-1:0]    in_vc,
  input  logic [DT_W-1:0]    in_dt,
  input  logic [NPORT-1:0]   port_ready,
  output logic               beat_valid,
  output logic [OUT_W-1:0]   beat_data,
  output logic [VC_W-1:0]    beat_vc,
  output logic [DT_W-1:0]    beat_dt
);
  logic               full_q, full_d;
  logic               hi_q, hi_d;
  logic [2*OUT_W-1:0] word_q;
  logic [VC_W-1:0]    vc_q;
  logic [DT_W-1:0]    dt_q;
  logic               take, accept;

  assign beat_valid = full_q & ~flush;
  assign take       = beat_valid & port_ready[vc_q];
  assign in_ready   = ~flush & (~full_q | (hi_q & take));
  assign accept     = in_valid & in_ready;

  always_comb begin
    full_d = full_q;
    hi_d   = hi_q;
    if (flush) begin
      full_d = 1'b0;
      hi_d   = 1'b0;
    end else begin
      if (take) begin
        if (hi_q) full_d = 1'b0;
        else      hi_d   = 1'b1;
      end
      if (accept) begin
        full_d = 1'b1;
        hi_d   = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      hi_q   <= 1'b0;
    end else begin
      full_q <= full_d;
      hi_q   <= hi_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      vc_q   <= '0;
      dt_q   <= '0;
    end else if (accept) begin
      word_q <= in_word;
      vc_q   <= in_vc;
      dt_q   <= in_dt;
    end
  end

  assign beat_data = hi_q ? word_q[2*OUT_W-1:OUT_W] : word_q[OUT_W-1:0];
  assign beat_vc   = vc_q;
  assign beat_dt   = dt_q;
endmodule

// File: rtl/vc_stream_gasket.sv
module vc_stream_gasket
  import vcg_pkg::*;
#(
  parameter int unsigned OUT_W = 16,
  parameter int unsigned VC_W  = 2,
  parameter int unsigned DT_W  = 6,
  parameter int unsigned REG_W = 32,
  parameter int unsigned NPORT = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_wr_en,
  input  logic [REG_W-1:0]      cfg_wr_data,
  output logic [REG_W-1:0]      cfg_rd_data,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [2*OUT_W-1:0]    in_data,
  input  logic [VC_W-1:0]       in_vc,
  input  logic [DT_W-1:0]       in_dt,
  output logic [NPORT-1:0]      out_valid,
  input  logic [NPORT-1:0]      out_ready,
  output logic [NPORT*OUT_W-1:0] out_data,
  output logic [NPORT*(VC_W+DT_W)-1:0] out_di,
  output logic [NPORT-1:0]      out_pclk_en
);
  localparam int unsigned IN_W = 2 * OUT_W;
  localparam int unsigned DI_W = VC_W + DT_W;

  vcg_cfg_t          cfg;
  logic [IN_W-1:0]   packed_word;
  logic              beat_valid;
  logic [OUT_W-1:0]  beat_data;
  logic [VC_W-1:0]   beat_vc;
  logic [DT_W-1:0]   beat_dt;

  vcg_ctrl_reg #(.REG_W(REG_W)) u_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .wr_data(cfg_wr_data),
    .cfg(cfg), .rd_data(cfg_rd_data)
  );

  vcg_packer #(.OUT_W(OUT_W), .DT_W(DT_W)) u_pack (
    .word_in(in_data), .dt(in_dt), .cfg(cfg), .word_out(packed_word)
  );

  vcg_beat_buf #(.OUT_W(OUT_W), .DT_W(DT_W), .VC_W(VC_W), .NPORT(NPORT)) u_buf (
    .clk(clk), .rst_n(rst_n), .flush(cfg.soft_rst),
    .in_valid(in_valid), .in_ready(in_ready), .in_word(packed_word),
    .in_vc(in_vc), .in_dt(in_dt), .port_ready(out_ready),
    .beat_valid(beat_valid), .beat_data(beat_data),
    .beat_vc(beat_vc), .beat_dt(beat_dt)
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    logic sel;
    assign sel            = beat_valid & (beat_vc == VC_W'(p));
    assign out_valid[p]   = sel;
    assign out_data[p*OUT_W +: OUT_W] = sel ? beat_data : '0;
    assign out_di[p*DI_W +: DI_W]     = sel ? {{VC_W{1'b0}}, beat_dt} : '0;
    assign out_pclk_en[p] = cfg.free_clk | sel;
  end
endmodule

// File: rtl/vcg_gasket_chk.sv
module vcg_gasket_chk #(
  parameter int unsigned NPORT = 4,
  parameter int unsigned OUT_W = 16,
  parameter int unsigned REG_W = 32
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   cfg_wr_en,
  input logic [REG_W-1:0]       cfg_wr_data,
  input logic [REG_W-1:0]       cfg_rd_data,
  input logic                   in_valid,
  input logic                   in_ready,
  input logic [NPORT-1:0]       out_valid,
  input logic [NPORT-1:0]       out_ready,
  input logic [NPORT*OUT_W-1:0] out_data,
  input logic [NPORT-1:0]       out_pclk_en
);
  logic srst_wr;
  assign srst_wr = cfg_wr_en & cfg_wr_data[0];

  // R2
  one_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(out_valid));

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(out_valid & ~out_ready)) && !srst_wr) |=> ($stable(out_valid) && $stable(out_data)));

  // R9
  accept_shows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !srst_wr) |=> (out_valid != '0));

  // R10
  soft_reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    srst_wr |=> ((out_valid == '0) && !in_ready));

  // R8
  free_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rd_data[1] |-> (&out_pclk_en));

  // R8
  gated_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rd_data[1] |-> (out_pclk_en == out_valid));
endmodule

bind vc_stream_gasket vcg_gasket_chk #(.NPORT(NPORT), .OUT_W(OUT_W), .REG_W(REG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
  .cfg_rd_data(cfg_rd_data), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .out_pclk_en(out_pclk_en)
);

// File: tb/tb_vc_stream_gasket.sv
module tb_vc_stream_gasket;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_wr_en;
  logic [31:0] cfg_wr_data;
  logic [31:0] cfg_rd_data;
  logic        in_valid;
  logic        in_ready;
  logic [31:0] in_data;
  logic [1:0]  in_vc;
  logic [5:0]  in_dt;
  logic [3:0]  out_valid;
  logic [3:0]  out_ready;
  logic [63:0] out_data;
  logic [31:0] out_di;
  logic [3:0]  out_pclk_en;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  vc_stream_gasket dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
    .cfg_rd_data(cfg_rd_data), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_vc(in_vc), .in_dt(in_dt), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_di(out_di),
    .out_pclk_en(out_pclk_en)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_beat(input logic [31:0] w, input logic [5:0] dt,
                                           input logic [3:0] cfg, input int idx);
    logic [15:0] h;
    h = (idx == 0) ? w[15:0] : w[31:16];
    if (dt == 6'h20) begin
      if (cfg[3]) return {h[11:8], 1'b0, h[7:4], 2'b00, h[3:0], 1'b0};
      else        return {4'h0, h[11:8], h[7:4], h[3:0]};
    end else if (dt == 6'h1E) begin
      if (cfg[2]) return h;
      else        return {h[7:0], h[15:8]};
    end
    return h;
  endfunction

  task automatic wr_cfg(input logic [31:0] v);
    @(negedge clk);
    cfg_wr_en = 1'b1;
    cfg_wr_data = v;
    @(posedge clk);
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic send_check(input logic [1:0] vc, input logic [5:0] dt,
                            input logic [31:0] w, input logic [3:0] cfg);
    string tag;
    logic [15:0] e;
    tag = (dt == 6'h20) ? "R5" : (dt == 6'h1E) ? "R6" : "R7/R1";
    @(negedge clk);
    in_valid = 1'b1; in_data = w; in_vc = vc; in_dt = dt;
    #1;
    chk(in_ready == 1'b1, "R9 idle ready", 64'(in_ready), 64'd1);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    for (int b = 0; b < 2; b++) begin
      e = exp_beat(w, dt, cfg, b);
      chk(out_valid == 4'(1 << vc), "R2 valid port", 64'(out_valid), 64'(1 << vc));
      chk(out_data == (64'(e) << (16 * vc)), tag, out_data, 64'(e) << (16 * vc));
      chk(out_di[8*vc +: 8] == {2'b00, dt}, "R3 identifier", 64'(out_di[8*vc +: 8]), 64'({2'b00, dt}));
      chk(out_pclk_en == (cfg[1] ? 4'hF : 4'(1 << vc)), "R8 pclk",
          64'(out_pclk_en), cfg[1] ? 64'hF : 64'(1 << vc));
      @(posedge clk);
      @(negedge clk);
    end
    chk(out_valid == 4'h0, "R1 two beats only", 64'(out_valid), 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R9 watchdog actual=%0d expected=%0d", 0, 1);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [5:0]  dts [4];
    logic [31:0] w;
    int n;
    dts[0] = 6'h20; dts[1] = 6'h1E; dts[2] = 6'h2A; dts[3] = 6'h24;
    rst_n = 1'b0; cfg_wr_en = 1'b0; cfg_wr_data = '0;
    in_valid = 1'b0; in_data = '0; in_vc = '0; in_dt = '0; out_ready = 4'hF;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(out_valid == 4'h0, "R11 valid in reset", 64'(out_valid), 64'd0);
    chk(in_ready == 1'b1, "R11 ready in reset", 64'(in_ready), 64'd1);
    chk(cfg_rd_data == 32'h0, "R4 reset value", 64'(cfg_rd_data), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 4'h0 && in_ready, "R11 after release", 64'({in_ready, out_valid}), 64'h10);
    chk(out_pclk_en == 4'h0, "R8 gated idle", 64'(out_pclk_en), 64'd0);

    // R4 reserved bits
    wr_cfg(32'hFFFF_FFF6);
    chk(cfg_rd_data == 32'h6, "R4 reserved readback", 64'(cfg_rd_data), 64'h6);
    chk(out_pclk_en == 4'hF, "R8 non-gated idle", 64'(out_pclk_en), 64'hF);

    // Sweep: mode bits x channel x data type
    n = 0;
    for (int m = 0; m < 8; m++) begin
      wr_cfg(32'(m << 1));
      for (int v = 0; v < 4; v++) begin
        for (int d = 0; d < 4; d++) begin
          n++;
          w = 32'h9E37_79B9 * 32'(n) + 32'h0F1E_2D3C;
          send_check(2'(v), dts[d], w, 4'(m << 1));
        end
      end
    end

    // R9 backpressure, wrong port ready must not drain port 1
    wr_cfg(32'h0);
    out_ready = 4'b1101;
    @(negedge clk);
    in_valid = 1'b1; in_data = 32'hA1B2_C3D4; in_vc = 2'd1; in_dt = 6'h2A;
    @(posedge clk);
    @(negedge clk);
    in_data = 32'h5566_7788; in_vc = 2'd2; in_dt = 6'h2B;
    for (int k = 0; k < 3; k++) begin
      #1;
      chk(out_valid == 4'b0010, "R9 stalled valid", 64'(out_valid), 64'h2);
      chk(out_data[31:16] == 16'hC3D4, "R9 stalled data", 64'(out_data[31:16]), 64'hC3D4);
      chk(in_ready == 1'b0, "R9 input held", 64'(in_ready), 64'd0);
      @(negedge clk);
    end
    out_ready = 4'hF;
    #1;
    chk(in_ready == 1'b0, "R9 first half pending", 64'(in_ready), 64'd0);
    @(posedge clk);
    @(negedge clk);
    chk(out_data[31:16] == 16'hA1B2, "R9 second half", 64'(out_data[31:16]), 64'hA1B2);
    chk(in_ready == 1'b1, "R9 ready on last beat", 64'(in_ready), 64'd1);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid == 4'b0100 && out_data[47:32] == 16'h7788, "R9 next word no loss",
        64'({out_valid, out_data[47:32]}), 64'h4_7788);
    chk(out_di[23:16] == 8'h2B, "R3 next identifier", 64'(out_di[23:16]), 64'h2B);
    @(posedge clk);
    @(negedge clk);
    chk(out_data[47:32] == 16'h5566, "R1 next high half", 64'(out_data[47:32]), 64'h5566);
    @(posedge clk);
    @(negedge clk);
    chk(out_valid == 4'h0, "R9 drained", 64'(out_valid), 64'd0);

    // R10 soft reset with a half-sent word
    out_ready = 4'h0;
    in_valid = 1'b1; in_data = 32'hDEAD_BEEF; in_vc = 2'd3; in_dt = 6'h2A;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    out_ready = 4'b1000;
    @(posedge clk);
    @(negedge clk);
    out_ready = 4'h0;
    chk(out_valid == 4'b1000 && out_data[63:48] == 16'hDEAD, "R10 half sent",
        64'({out_valid, out_data[63:48]}), 64'h8_DEAD);
    wr_cfg(32'h1);
    in_valid = 1'b1; in_data = 32'h1234_5678; in_vc = 2'd0; in_dt = 6'h2A;
    for (int k = 0; k < 2; k++) begin
      #1;
      chk(out_valid == 4'h0, "R10 outputs idle", 64'(out_valid), 64'd0);
      chk(in_ready == 1'b0, "R10 input blocked", 64'(in_ready), 64'd0);
      @(negedge clk);
    end
    in_valid = 1'b0;
    out_ready = 4'hF;
    wr_cfg(32'h0);
    chk(out_valid == 4'h0, "R10 half word discarded", 64'(out_valid), 64'd0);
    send_check(2'd0, 6'h2A, 32'h1234_5678, 4'h0);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule